// File: doc/BRIEF.md
# Low-Power Snoop State Controller

This controller sequences a processor core through its idle states while keeping it able to answer coherency snoops from the system bus. The core runs in Normal. A stop-grant request parks it in Stop-Grant. A halt request parks it in one of two power-down states: plain halt, or a reduced halt that keeps the core at a lower clock ratio and supply point. A wake event returns it to Normal.

A snoop-start strobe that arrives while the core is parked moves the controller into a snoop state. It stays there until the snoop-serviced indication comes back, no matter which bus agent serviced the snoop. It then goes back to the idle state it left. The controller records that state when the snoop begins. A snoop taken from the reduced halt uses its own snoop state, which keeps the low operating point selected throughout.

If a wake event arrives during a snoop, the controller holds it until the snoop is serviced and then leaves to Normal. The enhanced-halt enable is read only at the moment halt is entered. The state register is one-hot, and every output is registered.

Top module: `lps_snoop_ctl`

## Requirements
- R1: After synchronous reset, state_oh is 6'h01 (Normal), clk_run is 1, low_op is 0 and snoop_act is 0. state_oh always has exactly one bit set, with this encoding: bit0 Normal, bit1 Stop-Grant, bit2 Halt, bit3 Reduced Halt, bit4 Snoop, bit5 Reduced Snoop.
- R2: In Normal, stopgnt_req moves the controller to Stop-Grant (6'h02) on the next edge. Otherwise halt_req moves it to Halt (6'h04) when ehalt_en is 0, or to Reduced Halt (6'h08) when ehalt_en is 1. stopgnt_req wins when both requests are high.
- R3: snoop_start in Stop-Grant or Halt moves the controller to Snoop (6'h10) on the next edge. snoop_start in Reduced Halt moves it to Reduced Snoop (6'h20).
- R4: A snoop state is held for as long as snoop_done stays low.
- R5: When snoop_done arrives and no wake is pending or present, the controller returns to the idle state the snoop was taken from (6'h02, 6'h04 or 6'h08).
- R6: low_op is 1 exactly when the state is Reduced Halt or Reduced Snoop.
- R7: clk_run is 1 in Normal, Snoop and Reduced Snoop, and 0 in the three idle states.
- R8: wake_evt in an idle state moves the controller to Normal. If snoop_start is high in the same cycle, the snoop is taken first and the wake is held pending.
- R9: A wake_evt seen during a snoop, or together with its snoop_done, sends the controller to Normal when snoop_done arrives. The pending wake is then cleared.
- R10: A change of ehalt_en while the controller is halted has no effect on the state or on low_op. The next halt entry uses the new value.
- R11: snoop_start in Normal has no effect.
- R12: snoop_act is 1 only in Snoop and Reduced Snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Request to enter halt power-down |
| stopgnt_req | input | 1 | Request to enter Stop-Grant |
| wake_evt | input | 1 | Wake or resume event |
| ehalt_en | input | 1 | Select the reduced halt on halt entry |
| snoop_start | input | 1 | A bus snoop begins |
| snoop_done | input | 1 | The snoop has been serviced |
| state_oh | output | 6 | One-hot current state |
| clk_run | output | 1 | Core clock-gate enable |
| low_op | output | 1 | Low ratio and voltage point selected |
| snoop_act | output | 1 | A snoop is being handled |

## Verification
The assertions assume that snoop_done is raised only while a snoop state is active and that snoop_start is not raised again during a snoop. The stimulus table respects both: each snoop-start is followed only by idle cycles, a wake, or the matching snoop-done. The transition properties also assume that a request does not collide with a wake in Normal. The vectors never raise halt or stop-grant requests together with a wake.

// File: rtl/lps_pkg.sv
package lps_pkg;
  localparam int NST = 6;

  typedef enum int unsigned {
    S_NORM = 0,
    S_STPG = 1,
    S_HALT = 2,
    S_EHLT = 3,
    S_SNP  = 4,
    S_ESNP = 5
  } st_idx_e;

  typedef logic [NST-1:0] st_vec_t;

  localparam st_vec_t ST_RESET = st_vec_t'(1) << S_NORM;
endpackage

// File: rtl/lps_next.sv
module lps_next
  import lps_pkg::*;
(
  input  st_vec_t cur,
  input  logic    halt_req,
  input  logic    stopgnt_req,
  input  logic    wake_evt,
  input  logic    wake_pend,
  input  logic    ret_halt,
  input  logic    ehalt_en,
  input  logic    snoop_start,
  input  logic    snoop_done,
  output st_vec_t nxt
);
  st_vec_t ret_vec;

  always_comb begin
    ret_vec = '0;
    if (ret_halt) ret_vec[S_HALT] = 1'b1;
    else          ret_vec[S_STPG] = 1'b1;
  end

  always_comb begin
    nxt = cur;
    if (cur[S_NORM]) begin
      if (stopgnt_req) begin
        nxt = '0; nxt[S_STPG] = 1'b1;
      end else if (halt_req) begin
        nxt = '0;
        if (ehalt_en) nxt[S_EHLT] = 1'b1;
        else          nxt[S_HALT] = 1'b1;
      end
    end else if (cur[S_STPG] || cur[S_HALT]) begin
      if (snoop_start) begin
        nxt = '0; nxt[S_SNP] = 1'b1;
      end else if (wake_evt) begin
        nxt = '0; nxt[S_NORM] = 1'b1;
      end
    end else if (cur[S_EHLT]) begin
      if (snoop_start) begin
        nxt = '0; nxt[S_ESNP] = 1'b1;
      end else if (wake_evt) begin
        nxt = '0; nxt[S_NORM] = 1'b1;
      end
    end else if (cur[S_SNP]) begin
      if (snoop_done) begin
        if (wake_pend || wake_evt) begin
          nxt = '0; nxt[S_NORM] = 1'b1;
        end else begin
          nxt = ret_vec;
        end
      end
    end else if (cur[S_ESNP]) begin
      if (snoop_done) begin
        nxt = '0;
        if (wake_pend || wake_evt) nxt[S_NORM] = 1'b1;
        else                       nxt[S_EHLT] = 1'b1;
      end
    end else begin
      nxt = ST_RESET;
    end
  end
endmodule

// File: rtl/lps_pend.sv
module lps_pend
  import lps_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  st_vec_t cur,
  input  logic    wake_evt,
  input  logic    snoop_start,
  input  logic    snoop_done,
  output logic    wake_pend,
  output logic    ret_halt
);
  logic in_snoop;
  logic idle_plain;
  logic idle_any;

  assign in_snoop   = cur[S_SNP] | cur[S_ESNP];
  assign idle_plain = cur[S_STPG] | cur[S_HALT];
  assign idle_any   = idle_plain | cur[S_EHLT];

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_pend <= 1'b0;
    end else if (in_snoop) begin
      if (snoop_done)    wake_pend <= 1'b0;
      else if (wake_evt) wake_pend <= 1'b1;
    end else if (idle_any && snoop_start) begin
      wake_pend <= wake_evt;
    end else begin
      wake_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                            ret_halt <= 1'b0;
    else if (idle_plain && snoop_start) ret_halt <= cur[S_HALT];
  end

  assert_pend_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (in_snoop && snoop_done) |=> !wake_pend);
endmodule

// File: rtl/lps_outdec.sv
module lps_outdec
  import lps_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  st_vec_t nxt,
  output logic    clk_run,
  output logic    low_op,
  output logic    snoop_act
);
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_run   <= 1'b1;
      low_op    <= 1'b0;
      snoop_act <= 1'b0;
    end else begin
      clk_run   <= nxt[S_NORM] | nxt[S_SNP] | nxt[S_ESNP];
      low_op    <= nxt[S_EHLT] | nxt[S_ESNP];
      snoop_act <= nxt[S_SNP] | nxt[S_ESNP];
    end
  end
endmodule

// File: rtl/lps_snoop_ctl.sv
module lps_snoop_ctl
  import lps_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           halt_req,
  input  logic           stopgnt_req,
  input  logic           wake_evt,
  input  logic           ehalt_en,
  input  logic           snoop_start,
  input  logic           snoop_done,
  output logic [NST-1:0] state_oh,
  output logic           clk_run,
  output logic           low_op,
  output logic           snoop_act
);
  st_vec_t st_q;
  st_vec_t st_d;
  logic    wake_pend;
  logic    ret_halt;

  lps_next u_next (
    .cur(st_q), .halt_req(halt_req), .stopgnt_req(stopgnt_req),
    .wake_evt(wake_evt), .wake_pend(wake_pend), .ret_halt(ret_halt),
    .ehalt_en(ehalt_en), .snoop_start(snoop_start),
    .snoop_done(snoop_done), .nxt(st_d)
  );

  lps_pend u_pend (
    .clk(clk), .rst(rst), .cur(st_q), .wake_evt(wake_evt),
    .snoop_start(snoop_start), .snoop_done(snoop_done),
    .wake_pend(wake_pend), .ret_halt(ret_halt)
  );

  lps_outdec u_out (
    .clk(clk), .rst(rst), .nxt(st_d),
    .clk_run(clk_run), .low_op(low_op), .snoop_act(snoop_act)
  );

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_RESET;
    else     st_q <= st_d;
  end

  assign state_oh = st_q;

  assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(st_q) == 1);

  assert_snoop_flag_R12: assert property (@(posedge clk) disable iff (rst)
    snoop_act |-> (st_q[S_SNP] || st_q[S_ESNP]));

  assert_low_point_R6: assert property (@(posedge clk) disable iff (rst)
    st_q[S_ESNP] |-> low_op);

  assert_snoop_entry_R3: assert property (@(posedge clk) disable iff (rst)
    ((st_q[S_STPG] || st_q[S_HALT]) && snoop_start) |=> st_q[S_SNP]);

  assert_snoop_hold_R4: assert property (@(posedge clk) disable iff (rst)
    ((st_q[S_SNP] || st_q[S_ESNP]) && !snoop_done) |=> $stable(st_q));

  assert_norm_ignore_R11: assert property (@(posedge clk) disable iff (rst)
    (st_q[S_NORM] && !halt_req && !stopgnt_req) |=> st_q[S_NORM]);
endmodule

// File: tb/sim_lps_snoop_ctl.sv
module sim_lps_snoop_ctl;
  localparam int CLK_PER = 10;
  localparam int NV = 27;

  // row: {halt, stopgnt, wake, ehalt_en, snoop_start, snoop_done, exp_state, req}
  localparam logic [15:0] VEC [NV] = '{
    {6'b010000, 6'h02, 4'd2},  // R2 stop-grant entry
    {6'b000010, 6'h10, 4'd3},  // R3 snoop from stop-grant
    {6'b000000, 6'h10, 4'd4},  // R4 held
    {6'b000001, 6'h02, 4'd5},  // R5 back to stop-grant
    {6'b001000, 6'h01, 4'd8},  // R8 wake
    {6'b100000, 6'h04, 4'd2},  // R2 plain halt
    {6'b000100, 6'h04, 4'd10}, // R10 enable change while halted
    {6'b000010, 6'h10, 4'd3},  // R3 snoop from halt
    {6'b001000, 6'h10, 4'd9},  // R9 wake held pending
    {6'b000001, 6'h01, 4'd9},  // R9 exit to normal
    {6'b100100, 6'h08, 4'd2},  // R2 reduced halt
    {6'b000010, 6'h20, 4'd3},  // R3 reduced snoop
    {6'b000000, 6'h20, 4'd4},  // R4 held
    {6'b000001, 6'h08, 4'd5},  // R5 back to reduced halt
    {6'b001010, 6'h20, 4'd8},  // R8 snoop wins over wake
    {6'b000001, 6'h01, 4'd9},  // R9 pending wake honoured
    {6'b000010, 6'h01, 4'd11}, // R11 snoop in normal ignored
    {6'b110000, 6'h02, 4'd2},  // R2 stop-grant priority
    {6'b100000, 6'h02, 4'd2},  // R2 halt ignored in stop-grant
    {6'b001000, 6'h01, 4'd8},  // R8 wake
    {6'b100000, 6'h04, 4'd10}, // R10 new enable used (0)
    {6'b000010, 6'h10, 4'd3},  // R3
    {6'b000001, 6'h04, 4'd5},  // R5 back to halt
    {6'b001000, 6'h01, 4'd8},  // R8
    {6'b100000, 6'h04, 4'd2},  // R2
    {6'b000010, 6'h10, 4'd3},  // R3
    {6'b001001, 6'h01, 4'd9}   // R9 wake with done
  };

  logic clk = 1'b0;
  logic rst, halt_req, stopgnt_req, wake_evt, ehalt_en, snoop_start, snoop_done;
  logic [5:0] state_oh;
  logic clk_run, low_op, snoop_act;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  lps_snoop_ctl u0 (
    .clk(clk), .rst(rst), .halt_req(halt_req), .stopgnt_req(stopgnt_req),
    .wake_evt(wake_evt), .ehalt_en(ehalt_en), .snoop_start(snoop_start),
    .snoop_done(snoop_done), .state_oh(state_oh), .clk_run(clk_run),
    .low_op(low_op), .snoop_act(snoop_act)
  );

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input int req, input logic [5:0] st);
    chk($sformatf("R%0d state", req), state_oh, st);
    chk("R6 low_op", {5'd0, low_op}, {5'd0, st[3] | st[5]});
    chk("R7 clk_run", {5'd0, clk_run}, {5'd0, st[0] | st[4] | st[5]});
    chk("R12 snoop_act", {5'd0, snoop_act}, {5'd0, st[4] | st[5]});
  endtask

  task automatic drive(input logic [5:0] v);
    {halt_req, stopgnt_req, wake_evt, ehalt_en, snoop_start, snoop_done} = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1;
    {halt_req, stopgnt_req, wake_evt, ehalt_en, snoop_start, snoop_done} = '0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk_all(1, 6'h01); // R1 reset state
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][15:10]);
      chk_all(int'(VEC[i][3:0]), VEC[i][9:4]);
    end
    drive(6'b100100);           // R2 into reduced halt
    chk_all(2, 6'h08);
    drive(6'b000000);           // R10 enable dropped, stays reduced
    chk_all(10, 6'h08);
    rst = 1'b1;                 // R1 reset while parked, snoop pending
    drive(6'b000010);
    chk_all(1, 6'h01);
    rst = 1'b0;
    drive(6'b000010);           // R11 ignored after reset
    chk_all(11, 6'h01);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PER * 5000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule